// File: doc/BRIEF.md
# Line Packetizer with Head-of-Line FIFO

This block turns a marked pixel stream into the packet sequence a serial camera link carries. A frame marker produces a four-byte frame-open short packet. Every video line then becomes one long packet, made of a four-byte header followed by the line's pixels. A frame-close marker produces a four-byte frame-close short packet. The output is a byte stream with one byte per clock while a packet is being sent, and first-byte and last-byte flags mark where each packet starts and ends. Checksum bytes are sent as zero, because their arithmetic is done further down the link.

Pixels arrive at most once every other clock, while bytes leave at up to one per clock. All markers and pixels pass through a tagged FIFO. While a line header is on the wire, the head of the line waits in the FIFO, and the faster drain then lets the line catch up. This lets the source run with as little as one blank pixel time between lines. The block also checks frame geometry: a frame whose width or height is not a multiple of eight is flagged. A sticky flag reports any marker or pixel dropped because the FIFO was full.

Top module: `line_packetizer`

## Requirements
- R1: A frame-open strobe (`in_fs`) yields the short packet bytes 0x00, 0x00, 0x00, 0x00, with `out_sop` on the first byte and `out_eop` on the fourth.
- R2: A frame-close strobe (`in_fe`) yields the short packet bytes 0x01, 0x00, 0x00, 0x00, with `out_sop` on the first byte and `out_eop` on the fourth. The packet is sent even when the frame is flagged as malformed.
- R3: A line-start strobe (`in_ls`) yields a header of four bytes: `cfg_dtype`, then `cfg_width` bits 7:0, then `cfg_width` bits 15:8, then 0x00. `out_sop` is set on the first of these bytes.
- R4: After the header, the long packet carries exactly `cfg_width` payload bytes, which are the pixels of that line in arrival order. `out_eop` is set on the last payload byte only.
- R5: Packets leave in the order their markers arrived: frame-open, then each line, then frame-close. Packets never interleave, and at least one idle cycle separates two packets.
- R6: When the block is idle and empty, the first byte of a packet is presented after the second rising edge that follows the cycle in which its strobe is held.
- R7: With pixels arriving no more often than every second clock, and with only the one-cycle line-start strobe as horizontal blanking, no byte is lost and `ovf_flag` stays low.
- R8: An entry offered while the FIFO is full is dropped, and `ovf_flag` rises and stays high until reset.
- R9: `dim_err` rises one edge after `in_fe` if the frame's line count, or the pixel count of any of its lines, is not a multiple of eight. It clears on the edge that samples the next `in_fs`.
- R10: After reset, `out_valid`, `ovf_flag` and `dim_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the input and output sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dtype | input | 8 | Data-type byte placed in each line header |
| cfg_width | input | 16 | Line length in bytes (one byte per pixel), sent as the word count |
| in_fs | input | 1 | Frame-open strobe, one cycle |
| in_fe | input | 1 | Frame-close strobe, one cycle |
| in_ls | input | 1 | Line-start strobe, one cycle, before the line's first pixel |
| in_valid | input | 1 | Pixel qualifier |
| in_pix | input | 8 | Pixel value |
| out_valid | output | 1 | Output byte is valid this cycle |
| out_byte | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| ovf_flag | output | 1 | Sticky FIFO-overflow flag |
| dim_err | output | 1 | Geometry error of the last closed frame |

## Verification
A strobe is written into the FIFO on the first rising edge and popped by the output sequencer on the second, so the first packet byte is due after the second edge. The latency test samples `out_valid` on the falling edge after each of these two edges. Every other data check works on a byte log gathered on falling edges, which compares order and content independently of exact timing. The flags change one edge after the strobe that causes them, so they are read on the following falling edge or later. The one exception is the sticky overflow flag, which is read again after a long idle period.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int PIX_W = 8;
    localparam int WC_W  = 16;

    localparam logic [7:0] DT_FRAME_OPEN  = 8'h00;
    localparam logic [7:0] DT_FRAME_CLOSE = 8'h01;

    typedef enum logic [1:0] {
        TAG_PIX = 2'd0,
        TAG_FS  = 2'd1,
        TAG_LS  = 2'd2,
        TAG_FE  = 2'd3
    } tag_e;

    typedef struct packed {
        tag_e             tag;
        logic [PIX_W-1:0] data;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHORT = 2'd1,
        TX_HDR   = 2'd2,
        TX_PAY   = 2'd3
    } tx_st_e;
endpackage

// File: rtl/lp_in_monitor.sv
module lp_in_monitor
    import lp_pkg::*;
#(
    parameter int PIX_CNT_W  = 13,
    parameter int LINE_CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_fs,
    input  logic       in_fe,
    input  logic       in_ls,
    input  logic       in_valid,
    input  logic [7:0] in_pix,
    output logic       wr_en,
    output entry_t     wr_entry,
    output logic       dim_err
);
    typedef struct packed {
        logic [PIX_CNT_W-1:0]  pix_cnt;
        logic [LINE_CNT_W-1:0] line_cnt;
        logic                  in_line;
        logic                  wbad;
        logic                  dim_err;
    } mon_s;

    mon_s s_d, s_q;
    logic line_ragged;

    always_comb begin
        s_d         = s_q;
        wr_en       = in_fs | in_fe | in_ls | in_valid;
        wr_entry    = '{tag: TAG_PIX, data: in_pix};
        line_ragged = s_q.in_line && (s_q.pix_cnt[2:0] != 3'd0);
        if (in_fs) begin
            wr_entry = '{tag: TAG_FS, data: '0};
            s_d      = '0;
        end else if (in_fe) begin
            wr_entry  = '{tag: TAG_FE, data: '0};
            s_d.dim_err = s_q.wbad | line_ragged | (s_q.line_cnt[2:0] != 3'd0);
            s_d.in_line = 1'b0;
        end else if (in_ls) begin
            wr_entry   = '{tag: TAG_LS, data: '0};
            s_d.wbad   = s_q.wbad | line_ragged;
            s_d.in_line = 1'b1;
            s_d.pix_cnt = '0;
            s_d.line_cnt = s_q.line_cnt + 1'b1;
        end else if (in_valid) begin
            s_d.pix_cnt = s_q.pix_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dim_err = s_q.dim_err;

    // R9
    dim_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dim_err) |-> $past(in_fe));
endmodule

// File: rtl/lp_fifo.sv
module lp_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_s;

    fifo_s s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign ovf   = s_q.ovf;
    assign rd_data = mem[s_q.rp];

    always_comb begin
        s_d   = s_q;
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        if (do_wr) s_d.wp = s_q.wp + 1'b1;
        if (do_rd) s_d.rp = s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + CW'(do_wr) - CW'(do_rd);
        if (wr_en && full) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[s_q.wp] <= wr_data;
    end

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    // R5
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/lp_tx.sv
module lp_tx
    import lp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      cfg_dtype,
    input  logic [WC_W-1:0] cfg_width,
    input  entry_t          head,
    input  logic            empty,
    output logic            pop,
    output logic            out_valid,
    output logic [7:0]      out_byte,
    output logic            out_sop,
    output logic            out_eop
);
    typedef struct packed {
        tx_st_e          st;
        logic [1:0]      idx;
        logic [WC_W-1:0] cnt;
        logic [WC_W-1:0] wc;
        logic [7:0]      dt;
    } tx_s;

    tx_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        pop       = 1'b0;
        out_valid = 1'b0;
        out_byte  = '0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        unique case (s_q.st)
            TX_IDLE: begin
                if (!empty) begin
                    pop   = 1'b1;
                    s_d.idx = '0;
                    unique case (head.tag)
                        TAG_FS: begin s_d.st = TX_SHORT; s_d.dt = DT_FRAME_OPEN;  end
                        TAG_FE: begin s_d.st = TX_SHORT; s_d.dt = DT_FRAME_CLOSE; end
                        TAG_LS: begin
                            s_d.st = TX_HDR;
                            s_d.dt = cfg_dtype;
                            s_d.wc = cfg_width;
                        end
                        default: ;
                    endcase
                end
            end
            TX_SHORT: begin
                out_valid = 1'b1;
                out_byte  = (s_q.idx == 2'd0) ? s_q.dt : 8'h00;
                out_sop   = (s_q.idx == 2'd0);
                out_eop   = (s_q.idx == 2'd3);
                s_d.idx   = s_q.idx + 1'b1;
                if (s_q.idx == 2'd3) s_d.st = TX_IDLE;
            end
            TX_HDR: begin
                out_valid = 1'b1;
                out_sop   = (s_q.idx == 2'd0);
                unique case (s_q.idx)
                    2'd0: out_byte = s_q.dt;
                    2'd1: out_byte = s_q.wc[7:0];
                    2'd2: out_byte = s_q.wc[15:8];
                    default: out_byte = 8'h00;
                endcase
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == 2'd3) begin
                    s_d.cnt = '0;
                    if (s_q.wc == '0) begin
                        out_eop = 1'b1;
                        s_d.st  = TX_IDLE;
                    end else begin
                        s_d.st  = TX_PAY;
                    end
                end
            end
            TX_PAY: begin
                if (!empty) begin
                    if (head.tag == TAG_PIX) begin
                        pop       = 1'b1;
                        out_valid = 1'b1;
                        out_byte  = head.data;
                        out_eop   = (s_q.cnt == s_q.wc - 1'b1);
                        s_d.cnt   = s_q.cnt + 1'b1;
                        if (out_eop) s_d.st = TX_IDLE;
                    end else begin
                        s_d.st = TX_IDLE;
                    end
                end
            end
            default: s_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: TX_IDLE, default: '0};
        else        s_q <= s_d;
    end

    // R1
    sop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);
    // R5
    eop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |=> !out_valid);
endmodule

// File: rtl/line_packetizer.sv
module line_packetizer
    import lp_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int PIX_CNT_W  = 13,
    parameter int LINE_CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cfg_dtype,
    input  logic [15:0] cfg_width,
    input  logic        in_fs,
    input  logic        in_fe,
    input  logic        in_ls,
    input  logic        in_valid,
    input  logic [7:0]  in_pix,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    output logic        out_sop,
    output logic        out_eop,
    output logic        ovf_flag,
    output logic        dim_err
);
    logic               wr_en, pop, empty, full;
    entry_t             wr_entry, head;
    logic [ENTRY_W-1:0] rd_bits;

    lp_in_monitor #(.PIX_CNT_W(PIX_CNT_W), .LINE_CNT_W(LINE_CNT_W)) mon_i (
        .clk(clk), .rst_n(rst_n),
        .in_fs(in_fs), .in_fe(in_fe), .in_ls(in_ls),
        .in_valid(in_valid), .in_pix(in_pix),
        .wr_en(wr_en), .wr_entry(wr_entry), .dim_err(dim_err)
    );

    lp_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_entry),
        .rd_en(pop), .rd_data(rd_bits),
        .empty(empty), .full(full), .ovf(ovf_flag)
    );

    assign head = entry_t'(rd_bits);

    lp_tx tx_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_dtype(cfg_dtype), .cfg_width(cfg_width),
        .head(head), .empty(empty), .pop(pop),
        .out_valid(out_valid), .out_byte(out_byte),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> ovf_flag);
endmodule

// File: tb/line_packetizer_tb.sv
module line_packetizer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  cfg_dtype = 8'h2A;
    logic [15:0] cfg_width = 16'd16;
    logic in_fs = 0, in_fe = 0, in_ls = 0, in_valid = 0;
    logic [7:0] in_pix = 0;
    logic out_valid, out_sop, out_eop, ovf_flag, dim_err;
    logic [7:0] out_byte;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [9:0] cap [4096];
    int ncap = 0;

    always #2.5 clk = ~clk;

    line_packetizer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dtype(cfg_dtype), .cfg_width(cfg_width),
        .in_fs(in_fs), .in_fe(in_fe), .in_ls(in_ls), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop), .out_eop(out_eop),
        .ovf_flag(ovf_flag), .dim_err(dim_err)
    );

    always @(negedge clk) begin
        if (out_valid && ncap < 4096) begin
            cap[ncap] <= {out_sop, out_eop, out_byte};
            ncap <= ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int l, input int i, input int seed);
        return 8'(l * 37 + i * 5 + seed);
    endfunction

    function automatic logic [9:0] get(input int idx);
        return (idx < ncap) ? cap[idx] : 10'h3FF;
    endfunction

    task automatic drive(input bit fs, input bit fe, input bit ls, input bit v, input logic [7:0] p);
        @(negedge clk);
        in_fs = fs; in_fe = fe; in_ls = ls; in_valid = v; in_pix = p;
    endtask

    task automatic idle(input int n);
        drive(0, 0, 0, 0, 8'h00);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        ncap = 0;
    endtask

    task automatic send_frame(input int w, input int h, input int gap, input int seed);
        drive(1, 0, 0, 0, 8'h00);
        for (int l = 0; l < h; l++) begin
            drive(0, 0, 1, 0, 8'h00);
            for (int i = 0; i < w; i++) begin
                drive(0, 0, 0, 1, pat(l, i, seed));
                for (int g = 0; g < gap; g++) drive(0, 0, 0, 0, 8'h00);
            end
        end
        drive(0, 1, 0, 0, 8'h00);
        idle(300);
    endtask

    task automatic check_short(input int pos, input logic [7:0] dt, input string req);
        int bad = 0;
        logic [9:0] e;
        for (int k = 0; k < 4; k++) begin
            e = {k == 0, k == 3, (k == 0) ? dt : 8'h00};
            if (get(pos + k) !== e) begin
                if (bad == 0) chk(0, req, int'(get(pos + k)), int'(e));
                bad++;
            end
        end
        if (bad == 0) chk(1, req, 0, 0);
    endtask

    task automatic check_frame(input int w, input int h, input logic [7:0] dt, input int seed);
        int pos = 4;
        logic [9:0] e;
        chk(ncap == 8 + h * (4 + w), "R5 total bytes", ncap, 8 + h * (4 + w));
        check_short(0, 8'h00, "R1 frame-open packet");
        for (int l = 0; l < h; l++) begin
            int hb = 0, pb = 0;
            for (int k = 0; k < 4; k++) begin
                case (k)
                    0: e = {2'b10, dt};
                    1: e = {2'b00, 8'(w)};
                    2: e = {2'b00, 8'(w >> 8)};
                    default: e = 10'h000;
                endcase
                if (get(pos + k) !== e && hb == 0) begin
                    chk(0, "R3 line header", int'(get(pos + k)), int'(e)); hb++;
                end
            end
            if (hb == 0) chk(1, "R3", 0, 0);
            pos += 4;
            for (int i = 0; i < w; i++) begin
                e = {1'b0, i == w - 1, pat(l, i, seed)};
                if (get(pos + i) !== e && pb == 0) begin
                    chk(0, "R4 payload", int'(get(pos + i)), int'(e)); pb++;
                end
            end
            if (pb == 0) chk(1, "R4", 0, 0);
            pos += w;
        end
        check_short(pos, 8'h01, "R2 frame-close packet");
    endtask

    task automatic t_reset();
        do_reset();
        chk(out_valid == 0, "R10 out_valid", out_valid, 0);
        chk(ovf_flag == 0, "R10 ovf_flag", ovf_flag, 0);
        chk(dim_err == 0, "R10 dim_err", dim_err, 0);
    endtask

    task automatic t_latency();
        ncap = 0;
        drive(1, 0, 0, 0, 8'h00);
        drive(0, 0, 0, 0, 8'h00);
        chk(out_valid == 0, "R6 not yet after first edge", out_valid, 0);
        @(negedge clk);
        chk(out_valid && out_sop && out_byte == 8'h00, "R6 first byte after second edge",
            {out_valid, out_sop}, 2'b11);
        drive(0, 1, 0, 0, 8'h00);
        idle(40);
        chk(ncap == 8, "R5 empty frame bytes", ncap, 8);
        check_short(0, 8'h00, "R1 frame-open");
        check_short(4, 8'h01, "R2 frame-close");
    endtask

    task automatic t_half_rate(input int w, input int h, input logic [7:0] dt, input int seed);
        ncap = 0;
        cfg_width = 16'(w); cfg_dtype = dt;
        send_frame(w, h, 1, seed);
        check_frame(w, h, dt, seed);
        chk(ovf_flag == 0, "R7 no overflow at one blank cycle", ovf_flag, 0);
        chk(dim_err == 0, "R9 good frame no error", dim_err, 0);
    endtask

    task automatic t_dim_err(input int w, input int h);
        ncap = 0;
        cfg_width = 16'(w); cfg_dtype = 8'h2B;
        send_frame(w, h, 1, 3);
        chk(dim_err == 1, "R9 bad geometry flagged", dim_err, 1);
        check_frame(w, h, 8'h2B, 3);
        drive(1, 0, 0, 0, 8'h00);
        drive(0, 0, 0, 0, 8'h00);
        chk(dim_err == 0, "R9 cleared by next frame-open", dim_err, 1'b0);
        drive(0, 1, 0, 0, 8'h00);
        idle(40);
    endtask

    task automatic t_overflow();
        do_reset();
        cfg_width = 16'd8; cfg_dtype = 8'h2A;
        send_frame(8, 40, 0, 9);
        chk(ovf_flag == 1, "R8 overflow raised", ovf_flag, 1);
        idle(500);
        chk(ovf_flag == 1, "R8 overflow sticky", ovf_flag, 1);
        do_reset();
        chk(ovf_flag == 0, "R10 overflow cleared by reset", ovf_flag, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_half_rate(16, 8, 8'h2A, 1);
        t_half_rate(8, 16, 8'h1E, 5);
        t_half_rate(24, 8, 8'h2C, 11);
        t_dim_err(12, 8);
        t_dim_err(8, 4);
        t_overflow();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule